// File: doc/BRIEF.md
# Load-Store Aliasing Predictor

This block decides, for every load that asks to issue in an out-of-order core, whether the load may run ahead of older stores whose addresses are not yet known. A load with no older unresolved store always issues at once. A load that does have such a store consults a per-PC confidence table. If the table holds full confidence, the load is hoisted speculatively and recorded. If it does not, the load is refused and the requester retries it later.

Stores enter a small tracking queue when they are dispatched. They leave the queue when their address resolves. Each resolving store address is compared in the same cycle against every younger speculative load that has already been hoisted. A match means the load read memory too early. One cycle later the block raises a flush that names the oldest offending load. It also discards all tracked loads and stores younger than that load and clears the confidence of the offending load's PC. Confidence builds back up as loads at that PC complete safely. Cache access and data forwarding happen outside this block.

Sequence numbers are 6 bits wide and wrap. Number a is older than number b when (a - b) mod 64 is 32 or more. All in-flight numbers must therefore lie within a span of 32.

Top module: `ld_alias_guard`

## Requirements
- R1: After reset no flush is raised, no load or store is tracked, and every one of the 64 confidence counters holds its maximum value 15, so hoisting is allowed by default.
- R2: A load request with no older unresolved store is granted in the same cycle with ld_spec_o low.
- R3: A load request with an older unresolved store is granted in the same cycle with ld_spec_o high only when all three hold: the counter selected by ld_req_pc_lo_i is 15, fewer than 8 speculative loads are tracked, and no store resolves in that cycle. Otherwise it is refused and both outputs stay low.
- R4: A refused load is granted non-speculatively on the first request made after every older store address has resolved.
- R5: A resolving store whose address equals that of a tracked younger speculative load raises flush_valid_o for exactly the following cycle. flush_seq_o then carries the sequence number of the oldest such load.
- R6: A resolving store raises no flush for loads older than itself, for loads with a different address, or for loads that were granted non-speculatively.
- R7: On a flush, the tracked loads with a sequence number equal to or younger than the flushed one are discarded, together with the pending stores younger than it. A later store resolving to their address does not flush them again.
- R8: The counter of a PC index is cleared to 0 by a violation of a load at that index. It increments by one, saturating at 15, when a load at that index is granted non-speculatively or when a speculative load at that index is released. A speculative load is released once no older unresolved store remains. A clear wins over an increment in the same cycle.
- R9: Age comparison of 6-bit sequence numbers wraps: a store numbered 62 is older than a load numbered 1.
- R10: At most 8 stores may wait for their address at once. A dispatch into a full queue is outside the contract.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| st_disp_valid_i | input | 1 | A store enters with its address unknown |
| st_disp_seq_i | input | 6 | Sequence number of the dispatched store |
| st_res_valid_i | input | 1 | A store's address becomes known |
| st_res_seq_i | input | 6 | Sequence number of the resolving store |
| st_res_addr_i | input | 16 | Resolved store address |
| ld_req_valid_i | input | 1 | A load asks to issue |
| ld_req_seq_i | input | 6 | Sequence number of the load |
| ld_req_pc_lo_i | input | 6 | Low PC bits of the load, selecting its counter |
| ld_req_addr_i | input | 16 | Load address |
| ld_grant_o | output | 1 | Load may issue this cycle |
| ld_spec_o | output | 1 | The grant is speculative, ahead of older unresolved stores |
| flush_valid_o | output | 1 | Ordering violation, one-cycle pulse |
| flush_seq_o | output | 6 | Sequence number of the offending load |

## Verification
The grant and speculation outputs answer a request in the same cycle. They depend only on state built at earlier edges, so the bench drives each request at the falling edge and samples a moment later. A flush is registered: it appears one cycle after the resolving store and is compared in the sample of the following step. Counter changes made at an edge first affect requests of the next cycle. The behavioural model updates its store list, load list and counters at each rising edge, using the inputs of the cycle just ended, and compares all four outputs every cycle. Directed cases cover wrap-around, multiple matches, squashing and retraining.

// File: rtl/lag_pkg.sv
package lag_pkg;
  // a is older than b under modulo-2^w arithmetic
  function automatic logic seq_older(input logic [31:0] a, input logic [31:0] b, input int w);
    logic [31:0] d;
    d = a - b;
    return d[w-1];
  endfunction
endpackage

// File: rtl/lag_store_tracker.sv
module lag_store_tracker import lag_pkg::*; #(
  parameter int SEQ_W = 6,
  parameter int DEPTH = 8
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         disp_valid_i,
  input  logic [SEQ_W-1:0]             disp_seq_i,
  input  logic                         res_valid_i,
  input  logic [SEQ_W-1:0]             res_seq_i,
  input  logic                         kill_valid_i,
  input  logic [SEQ_W-1:0]             kill_seq_i,
  output logic [DEPTH-1:0]             pend_o,
  output logic [DEPTH-1:0][SEQ_W-1:0]  seq_o,
  output logic                         res_hit_o,
  output logic                         full_o
);
  localparam int PTR_W = $clog2(DEPTH);

  logic [DEPTH-1:0]            valid_q, valid_d;
  logic [DEPTH-1:0][SEQ_W-1:0] seq_q, seq_d;
  logic [PTR_W-1:0]            alloc_ptr;

  assign pend_o = valid_q;
  assign seq_o  = seq_q;
  assign full_o = &valid_q;

  always_comb begin
    res_hit_o = 1'b0;
    for (int i = 0; i < DEPTH; i++)
      if (res_valid_i && valid_q[i] && seq_q[i] == res_seq_i) res_hit_o = 1'b1;
  end

  always_comb begin
    alloc_ptr = '0;
    for (int i = DEPTH-1; i >= 0; i--)
      if (!valid_q[i]) alloc_ptr = PTR_W'(i);
  end

  always_comb begin
    valid_d = valid_q;
    seq_d   = seq_q;
    for (int i = 0; i < DEPTH; i++)
      if (res_valid_i && valid_q[i] && seq_q[i] == res_seq_i) valid_d[i] = 1'b0;
    if (disp_valid_i && !full_o) begin
      valid_d[alloc_ptr] = 1'b1;
      seq_d[alloc_ptr]   = disp_seq_i;
    end
    // drop stores younger than the flushed load
    for (int i = 0; i < DEPTH; i++)
      if (kill_valid_i && valid_d[i] && seq_older(32'(kill_seq_i), 32'(seq_d[i]), SEQ_W))
        valid_d[i] = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= '0;
      seq_q   <= '0;
    end else begin
      valid_q <= valid_d;
      seq_q   <= seq_d;
    end
  end
endmodule

// File: rtl/lag_load_tracker.sv
module lag_load_tracker import lag_pkg::*; #(
  parameter int SEQ_W    = 6,
  parameter int ADDR_W   = 16,
  parameter int IDX_W    = 6,
  parameter int DEPTH    = 8,
  parameter int SQ_DEPTH = 8
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           ins_valid_i,
  input  logic [SEQ_W-1:0]               ins_seq_i,
  input  logic [ADDR_W-1:0]              ins_addr_i,
  input  logic [IDX_W-1:0]               ins_idx_i,
  input  logic                           res_valid_i,
  input  logic [SEQ_W-1:0]               res_seq_i,
  input  logic [ADDR_W-1:0]              res_addr_i,
  input  logic [SQ_DEPTH-1:0]            sq_pend_i,
  input  logic [SQ_DEPTH-1:0][SEQ_W-1:0] sq_seq_i,
  output logic                           full_o,
  output logic                           viol_o,
  output logic [SEQ_W-1:0]               viol_seq_o,
  output logic [IDX_W-1:0]               viol_idx_o,
  output logic [DEPTH-1:0]               rel_o,
  output logic [DEPTH-1:0][IDX_W-1:0]    rel_idx_o
);
  localparam int PTR_W = $clog2(DEPTH);

  logic [DEPTH-1:0]             valid_q, valid_d;
  logic [DEPTH-1:0][SEQ_W-1:0]  seq_q, seq_d;
  logic [DEPTH-1:0][ADDR_W-1:0] addr_q, addr_d;
  logic [DEPTH-1:0][IDX_W-1:0]  idx_q, idx_d;
  logic [DEPTH-1:0]             hit;
  logic [PTR_W-1:0]             ins_ptr;

  assign full_o    = &valid_q;
  assign rel_idx_o = idx_q;

  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      logic blk;
      blk = 1'b0;
      for (int j = 0; j < SQ_DEPTH; j++)
        if (sq_pend_i[j] && seq_older(32'(sq_seq_i[j]), 32'(seq_q[i]), SEQ_W)) blk = 1'b1;
      rel_o[i] = valid_q[i] && !blk;
      hit[i]   = valid_q[i] && res_valid_i && addr_q[i] == res_addr_i &&
                 seq_older(32'(res_seq_i), 32'(seq_q[i]), SEQ_W);
    end
  end

  // oldest matching load wins
  always_comb begin
    viol_o     = 1'b0;
    viol_seq_o = '0;
    viol_idx_o = '0;
    for (int i = 0; i < DEPTH; i++)
      if (hit[i] && (!viol_o || seq_older(32'(seq_q[i]), 32'(viol_seq_o), SEQ_W))) begin
        viol_o     = 1'b1;
        viol_seq_o = seq_q[i];
        viol_idx_o = idx_q[i];
      end
  end

  always_comb begin
    ins_ptr = '0;
    for (int i = DEPTH-1; i >= 0; i--)
      if (!valid_q[i]) ins_ptr = PTR_W'(i);
  end

  always_comb begin
    valid_d = valid_q & ~rel_o;
    seq_d   = seq_q;
    addr_d  = addr_q;
    idx_d   = idx_q;
    for (int i = 0; i < DEPTH; i++)
      if (viol_o && valid_q[i] && !seq_older(32'(seq_q[i]), 32'(viol_seq_o), SEQ_W))
        valid_d[i] = 1'b0;
    if (ins_valid_i && !full_o) begin
      valid_d[ins_ptr] = 1'b1;
      seq_d[ins_ptr]   = ins_seq_i;
      addr_d[ins_ptr]  = ins_addr_i;
      idx_d[ins_ptr]   = ins_idx_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= '0;
      seq_q   <= '0;
      addr_q  <= '0;
      idx_q   <= '0;
    end else begin
      valid_q <= valid_d;
      seq_q   <= seq_d;
      addr_q  <= addr_d;
      idx_q   <= idx_d;
    end
  end
endmodule

// File: rtl/lag_predictor.sv
module lag_predictor #(
  parameter int IDX_W = 6,
  parameter int CNT_W = 4,
  parameter int N_REL = 8
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic [IDX_W-1:0]            rd_idx_i,
  output logic                        allow_o,
  input  logic                        grant_inc_i,
  input  logic [IDX_W-1:0]            grant_idx_i,
  input  logic [N_REL-1:0]            rel_i,
  input  logic [N_REL-1:0][IDX_W-1:0] rel_idx_i,
  input  logic                        clr_i,
  input  logic [IDX_W-1:0]            clr_idx_i
);
  localparam int ENTRIES = 1 << IDX_W;
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_all [ENTRIES];

  for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
    logic [CNT_W-1:0] cnt_q;
    logic             inc;

    always_comb begin
      inc = grant_inc_i && grant_idx_i == IDX_W'(e);
      for (int k = 0; k < N_REL; k++)
        if (rel_i[k] && rel_idx_i[k] == IDX_W'(e)) inc = 1'b1;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                              cnt_q <= CNT_MAX;
      else if (clr_i && clr_idx_i == IDX_W'(e)) cnt_q <= '0;
      else if (inc && cnt_q != CNT_MAX)         cnt_q <= cnt_q + 1'b1;
    end

    assign cnt_all[e] = cnt_q;
  end

  assign allow_o = cnt_all[rd_idx_i] == CNT_MAX;
endmodule

// File: rtl/ld_alias_guard.sv
module ld_alias_guard import lag_pkg::*; #(
  parameter int SEQ_W      = 6,
  parameter int ADDR_W     = 16,
  parameter int PRED_IDX_W = 6,
  parameter int CNT_W      = 4,
  parameter int SQ_DEPTH   = 8,
  parameter int LQ_DEPTH   = 8
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  st_disp_valid_i,
  input  logic [SEQ_W-1:0]      st_disp_seq_i,
  input  logic                  st_res_valid_i,
  input  logic [SEQ_W-1:0]      st_res_seq_i,
  input  logic [ADDR_W-1:0]     st_res_addr_i,
  input  logic                  ld_req_valid_i,
  input  logic [SEQ_W-1:0]      ld_req_seq_i,
  input  logic [PRED_IDX_W-1:0] ld_req_pc_lo_i,
  input  logic [ADDR_W-1:0]     ld_req_addr_i,
  output logic                  ld_grant_o,
  output logic                  ld_spec_o,
  output logic                  flush_valid_o,
  output logic [SEQ_W-1:0]      flush_seq_o
);
  logic [SQ_DEPTH-1:0]                 sq_pend;
  logic [SQ_DEPTH-1:0][SEQ_W-1:0]      sq_seq;
  logic                                sq_res_hit, sq_full, lt_full;
  logic                                viol;
  logic [SEQ_W-1:0]                    viol_seq;
  logic [PRED_IDX_W-1:0]               viol_idx;
  logic [LQ_DEPTH-1:0]                 rel;
  logic [LQ_DEPTH-1:0][PRED_IDX_W-1:0] rel_idx;
  logic                                pred_allow, older_pend, spec_ok;
  logic                                flush_q;
  logic [SEQ_W-1:0]                    flush_seq_q;

  always_comb begin
    older_pend = 1'b0;
    for (int j = 0; j < SQ_DEPTH; j++)
      if (sq_pend[j] && seq_older(32'(sq_seq[j]), 32'(ld_req_seq_i), SEQ_W)) older_pend = 1'b1;
  end

  // no hoisting while a store resolves: its compare would miss the new entry
  assign spec_ok    = pred_allow && !lt_full && !st_res_valid_i;
  assign ld_grant_o = ld_req_valid_i && (!older_pend || spec_ok);
  assign ld_spec_o  = ld_req_valid_i && older_pend && spec_ok;

  lag_store_tracker #(.SEQ_W(SEQ_W), .DEPTH(SQ_DEPTH)) i_sq (
    .clk_i, .rst_ni,
    .disp_valid_i (st_disp_valid_i),
    .disp_seq_i   (st_disp_seq_i),
    .res_valid_i  (st_res_valid_i),
    .res_seq_i    (st_res_seq_i),
    .kill_valid_i (viol),
    .kill_seq_i   (viol_seq),
    .pend_o       (sq_pend),
    .seq_o        (sq_seq),
    .res_hit_o    (sq_res_hit),
    .full_o       (sq_full)
  );

  lag_load_tracker #(.SEQ_W(SEQ_W), .ADDR_W(ADDR_W), .IDX_W(PRED_IDX_W),
                     .DEPTH(LQ_DEPTH), .SQ_DEPTH(SQ_DEPTH)) i_lt (
    .clk_i, .rst_ni,
    .ins_valid_i (ld_spec_o),
    .ins_seq_i   (ld_req_seq_i),
    .ins_addr_i  (ld_req_addr_i),
    .ins_idx_i   (ld_req_pc_lo_i),
    .res_valid_i (sq_res_hit),
    .res_seq_i   (st_res_seq_i),
    .res_addr_i  (st_res_addr_i),
    .sq_pend_i   (sq_pend),
    .sq_seq_i    (sq_seq),
    .full_o      (lt_full),
    .viol_o      (viol),
    .viol_seq_o  (viol_seq),
    .viol_idx_o  (viol_idx),
    .rel_o       (rel),
    .rel_idx_o   (rel_idx)
  );

  lag_predictor #(.IDX_W(PRED_IDX_W), .CNT_W(CNT_W), .N_REL(LQ_DEPTH)) i_pred (
    .clk_i, .rst_ni,
    .rd_idx_i    (ld_req_pc_lo_i),
    .allow_o     (pred_allow),
    .grant_inc_i (ld_grant_o && !older_pend),
    .grant_idx_i (ld_req_pc_lo_i),
    .rel_i       (rel),
    .rel_idx_i   (rel_idx),
    .clr_i       (viol),
    .clr_idx_i   (viol_idx)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flush_q     <= 1'b0;
      flush_seq_q <= '0;
    end else begin
      flush_q     <= viol;
      flush_seq_q <= viol_seq;
    end
  end

  assign flush_valid_o = flush_q;
  assign flush_seq_o   = flush_seq_q;
endmodule

// File: rtl/ld_alias_guard_chk.sv
module ld_alias_guard_chk #(
  parameter int SEQ_W    = 6,
  parameter int SQ_DEPTH = 8
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                st_disp_valid_i,
  input logic                st_res_valid_i,
  input logic                ld_req_valid_i,
  input logic                ld_grant_o,
  input logic                ld_spec_o,
  input logic                flush_valid_o,
  input logic [SEQ_W-1:0]    flush_seq_o,
  input logic [SQ_DEPTH-1:0] sq_pend,
  input logic                sq_full
);
  AST_GRANT_NEEDS_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_grant_o |-> ld_req_valid_i); // R2
  AST_SPEC_IS_GRANT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_spec_o |-> ld_grant_o); // R3
  AST_SPEC_NEEDS_STORE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_spec_o |-> (|sq_pend)); // R3
  AST_NO_SPEC_ON_RESOLVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_res_valid_i |-> !ld_spec_o); // R3
  AST_FLUSH_AFTER_RESOLVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_valid_o |-> $past(st_res_valid_i)); // R5
  AST_FLUSH_SEQ_KNOWN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_valid_o |-> !$isunknown(flush_seq_o)); // R5
  AST_SQ_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sq_full |-> !st_disp_valid_i); // R10
endmodule

bind ld_alias_guard ld_alias_guard_chk #(.SEQ_W(SEQ_W), .SQ_DEPTH(SQ_DEPTH)) i_chk (
  .clk_i           (clk_i),
  .rst_ni          (rst_ni),
  .st_disp_valid_i (st_disp_valid_i),
  .st_res_valid_i  (st_res_valid_i),
  .ld_req_valid_i  (ld_req_valid_i),
  .ld_grant_o      (ld_grant_o),
  .ld_spec_o       (ld_spec_o),
  .flush_valid_o   (flush_valid_o),
  .flush_seq_o     (flush_seq_o),
  .sq_pend         (sq_pend),
  .sq_full         (sq_full)
);

// File: tb/test_ld_alias_guard.sv
module test_ld_alias_guard;
  localparam int CLK_PERIOD = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        st_disp_valid_i = 1'b0;
  logic [5:0]  st_disp_seq_i = '0;
  logic        st_res_valid_i = 1'b0;
  logic [5:0]  st_res_seq_i = '0;
  logic [15:0] st_res_addr_i = '0;
  logic        ld_req_valid_i = 1'b0;
  logic [5:0]  ld_req_seq_i = '0;
  logic [5:0]  ld_req_pc_lo_i = '0;
  logic [15:0] ld_req_addr_i = '0;
  logic        ld_grant_o, ld_spec_o, flush_valid_o;
  logic [5:0]  flush_seq_o;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  ld_alias_guard i_ld_alias_guard (.*);

  typedef struct { int seq; int addr; int idx; } ld_t;

  int  total = 0, bad = 0;
  bit  finished = 0;
  int  sq[$];
  ld_t lt[$];
  int  ctr[64];
  bit  fl_exp = 0;
  int  fs_exp = 0;
  int  last_grant, last_spec, last_flush, last_fseq;

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  function automatic bit older_store(input int s);
    foreach (sq[k]) if (sq[k] < s) return 1;
    return 0;
  endfunction

  task automatic step(input bit sd, input int sds, input bit sr, input int srs, input int sra,
                      input bit lr, input int ls, input int lpc, input int la);
    bit op, spec, grant, viol, hit;
    int vseq, vidx;
    bit mark[64];
    ld_t keep[$];
    st_disp_valid_i = sd;  st_disp_seq_i = 6'(sds);
    st_res_valid_i  = sr;  st_res_seq_i  = 6'(srs); st_res_addr_i = 16'(sra);
    ld_req_valid_i  = lr;  ld_req_seq_i  = 6'(ls);  ld_req_pc_lo_i = 6'(lpc); ld_req_addr_i = 16'(la);
    #1;
    op    = lr && older_store(ls);
    spec  = lr && op && ctr[lpc & 63] == 15 && lt.size() < 8 && !sr;
    grant = lr && (!op || spec);
    chk("R3 grant", int'(ld_grant_o), int'(grant));
    chk("R3 spec", int'(ld_spec_o), int'(spec));
    chk("R5 flush valid", int'(flush_valid_o), int'(fl_exp));
    if (fl_exp) chk("R5 flush seq", int'(flush_seq_o), fs_exp & 63);
    last_grant = int'(ld_grant_o); last_spec = int'(ld_spec_o);
    last_flush = int'(flush_valid_o); last_fseq = int'(flush_seq_o);
    @(posedge clk_i);
    // model update from the state before this edge
    foreach (mark[k]) mark[k] = 0;
    foreach (lt[k]) begin
      if (!older_store(lt[k].seq)) mark[lt[k].idx] = 1;
      else keep.push_back(lt[k]);
    end
    viol = 0; vseq = 0; vidx = 0; hit = 0;
    foreach (sq[k]) if (sr && sq[k] == srs) hit = 1;
    if (hit)
      foreach (lt[k])
        if (lt[k].seq > srs && lt[k].addr == sra && (!viol || lt[k].seq < vseq)) begin
          viol = 1; vseq = lt[k].seq; vidx = lt[k].idx;
        end
    if (hit) foreach (sq[k]) if (sq[k] == srs) begin sq.delete(k); break; end
    if (sd) sq.push_back(sds);
    if (viol) for (int k = sq.size()-1; k >= 0; k--) if (sq[k] > vseq) sq.delete(k);
    if (viol) for (int k = keep.size()-1; k >= 0; k--) if (keep[k].seq >= vseq) keep.delete(k);
    if (spec) keep.push_back('{ls, la, lpc & 63});
    lt = keep;
    if (grant && !op) mark[lpc & 63] = 1;
    foreach (mark[k]) if (mark[k] && ctr[k] < 15) ctr[k]++;
    if (viol) ctr[vidx] = 0;
    fl_exp = viol; fs_exp = vseq;
    @(negedge clk_i);
    st_disp_valid_i = 0; st_res_valid_i = 0; ld_req_valid_i = 0;
  endtask

  task automatic idle(); step(0,0,0,0,0,0,0,0,0); endtask
  task automatic sdisp(input int s); step(1,s,0,0,0,0,0,0,0); endtask
  task automatic sres(input int s, input int a); step(0,0,1,s,a,0,0,0,0); endtask
  task automatic lreq(input int s, input int pc, input int a); step(0,0,0,0,0,1,s,pc,a); endtask

  initial begin
    #(CLK_PERIOD*200000);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog act=hung exp=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int ns;
    foreach (ctr[k]) ctr[k] = 15;
    repeat (3) @(negedge clk_i);
    chk("R1 flush at reset", int'(flush_valid_o), 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    idle();
    chk("R1 no flush", last_flush, 0);

    lreq(1, 3, 'h100);
    chk("R2 plain grant", last_grant, 1);
    chk("R2 not spec", last_spec, 0);

    // default hoisting, store resolves elsewhere
    sdisp(2); lreq(3, 3, 'h100);
    chk("R1 hoist allowed", last_spec, 1);
    sres(2, 'h200); idle();
    chk("R6 diff addr no flush", last_flush, 0);

    // violation, then refusal and later plain grant
    sdisp(4); lreq(5, 3, 'h300); sres(4, 'h300); idle();
    chk("R5 flush raised", last_flush, 1);
    chk("R5 flush seq", last_fseq, 5);
    idle();
    chk("R5 one cycle", last_flush, 0);
    sdisp(6); lreq(7, 3, 'h300);
    chk("R8 cleared counter refuses", last_grant, 0);
    sres(6, 'h500); lreq(7, 3, 'h300);
    chk("R4 granted after resolve", last_grant, 1);
    chk("R4 not spec", last_spec, 0);
    // counter now 1; 13 more plain grants -> 14
    for (int i = 0; i < 13; i++) lreq(8 + i, 3, 'h300);
    sdisp(21); lreq(22, 3, 'h300);
    chk("R8 counter 14 refuses", last_grant, 0);
    sres(21, 'h700); lreq(22, 3, 'h300);
    sdisp(23); lreq(24, 3, 'h300);
    chk("R8 retrained hoists", last_spec, 1);
    sres(23, 'h900); idle(); idle();

    // two matches: oldest flushed, younger squashed
    sdisp(25); sdisp(26); lreq(27, 10, 'h40); lreq(28, 11, 'h40);
    sres(26, 'h40); idle();
    chk("R5 oldest of two", last_fseq, 27);
    sres(25, 'h40); idle();
    chk("R7 squashed load silent", last_flush, 0);
    lreq(29, 11, 'h40);
    chk("R7 younger pc untouched", last_grant, 1);

    // younger store and same-cycle resolve
    sdisp(30); lreq(31, 12, 'h60); sdisp(32);
    step(0,0,1,32,'h60,1,33,12,'h60);
    chk("R3 no hoist while resolving", last_grant, 0);
    idle();
    chk("R6 younger store no flush", last_flush, 0);
    sres(30, 'h0); idle(); idle();

    // table full
    sdisp(34);
    for (int i = 0; i < 8; i++) lreq(35 + i, 20, 'h1000 + i);
    lreq(43, 20, 'h2000);
    chk("R3 full table refuses", last_grant, 0);
    sres(34, 'h9); idle(); lreq(44, 20, 'h2000);
    chk("R3 drained table", last_grant, 1);
    idle();

    // wrap-around ages
    sdisp(62); lreq(65, 30, 'h77);
    chk("R9 wrapped store older", last_spec, 1);
    sres(62, 'h77); idle();
    chk("R9 wrapped flush seq", last_fseq, 1);
    idle(); idle();

    // mixed traffic
    ns = 70;
    for (int c = 0; c < 4000; c++) begin
      bit sd, sr, lr;
      int sds, srs, sra, ls, lpc, la;
      sd = sq.size() < 6 && ($urandom % 3 == 0);
      sds = ns; if (sd) ns++;
      sr = 0; srs = 0;
      if (sq.size() > 0) begin
        int mn;
        mn = sq[0];
        foreach (sq[k]) if (sq[k] < mn) mn = sq[k];
        if (ns - mn > 16) begin sr = 1; srs = mn; end
        else if ($urandom % 3 == 0) begin sr = 1; srs = sq[$urandom % sq.size()]; end
      end
      sra = 16 * (1 + $urandom % 4);
      lr = $urandom % 2;
      ls = ns; if (lr) ns++;
      case ($urandom % 4)
        0: lpc = 1; 1: lpc = 2; 2: lpc = 3; default: lpc = 5;
      endcase
      la = 16 * (1 + $urandom % 4);
      step(sd, sds, sr, srs, sra, lr, ls, lpc, la);
    end

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule